// File: doc/BRIEF.md
# Bit-Sequential 16-bit Carrier Register

This block is a 16-bit general-purpose register that sits in the upper bank of a processor's data memory. The register-file port can read or write it one bit, one 4-bit nibble or one 8-bit byte at a time. The index on that port selects the bit, the nibble or the byte. Reads are combinational. Writes take effect on the rising clock edge.

Software can also reach a single bit indirectly. In that mode the bit index comes from an external 4-bit pointer instead of from the access index. Software moves the pointer up or down by one and reads or writes one bit per step, so the register serves as a 16-bit serial pattern in any bit order. A dedicated output always shows the bit the pointer currently selects. A second consumer can therefore stream the pattern out without going through the read port.

Top module: `bsc_carrier`

## Requirements
- R1: While reset is asserted and after it is released, the register holds all zeros: every byte read returns 0 and the pointer output is 0 for every pointer value.
- R2: A bit-width write (width code 0) stores `wdata[0]` at bit `acc_idx[3:0]` and leaves the other 15 bits unchanged.
- R3: A nibble-width write (width code 1) stores `wdata[3:0]` into bits `4*acc_idx[1:0]+3 .. 4*acc_idx[1:0]` and leaves the other 12 bits unchanged.
- R4: A byte-width write (width code 2) stores `wdata[7:0]` into bits `8*acc_idx[0]+7 .. 8*acc_idx[0]`. Byte accesses are always aligned.
- R5: When `acc_ind` is high on a bit-width access, the bit index comes from `ptr` and `acc_idx` is ignored, for both read and write.
- R6: `seq_bit` equals the register bit at position `ptr`, updates combinationally when `ptr` changes, and follows the pointer when it steps upward through 15 to 0 or downward through 0 to 15.
- R7: `rdata` returns the selected bit, nibble or byte (same index rules as R2 to R5), zero-extended to 8 bits.
- R8: Width code 3 is reserved: a write with it leaves the register unchanged and a read with it returns 0.
- R9: No write happens unless both `acc_en` and `acc_wr` are high at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_en | input | 1 | Access strobe for the register |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_width | input | 2 | 0 bit, 1 nibble, 2 byte, 3 reserved |
| acc_idx | input | 4 | Bit index, nibble index in [1:0], byte index in [0] |
| acc_ind | input | 1 | Take the bit index from `ptr` for a bit-width access |
| ptr | input | 4 | External sequential bit pointer |
| wdata | input | 8 | Write data, right-aligned |
| rdata | output | 8 | Read data, zero-extended |
| seq_bit | output | 1 | Register bit selected by `ptr` |

## Verification
The hardest case is a pointer-indexed write. A fault there can hide if `acc_idx` happens to equal the pointer. The stimulus therefore holds `acc_idx` at the bitwise complement of `ptr` on every indirect access. It then steps the pointer upward past 15 and downward past 0, so a wrong index source always lands on a different bit. After each write the whole register is read back through all four nibbles. The pointer output is also swept in both directions over a pattern that no shift or rotation of itself reproduces.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
    typedef enum logic [1:0] {
        ACC_BIT  = 2'd0,
        ACC_NIB  = 2'd1,
        ACC_BYTE = 2'd2,
        ACC_RSVD = 2'd3
    } acc_width_e;
endpackage

// File: rtl/bsc_write_lanes.sv
// Turns an access width and index into a per-bit write mask and
// the matching replicated write value.
module bsc_write_lanes
    import bsc_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int NIB_W  = 4,
    parameter int BYTE_W = 8,
    localparam int IDX_W  = $clog2(REG_W),
    localparam int NSEL_W = $clog2(REG_W / NIB_W),
    localparam int BSEL_W = (REG_W / BYTE_W) > 1 ? $clog2(REG_W / BYTE_W) : 1,
    localparam int NIB_SH = $clog2(NIB_W),
    localparam int BYT_SH = $clog2(BYTE_W)
) (
    input  acc_width_e          width,
    input  logic [IDX_W-1:0]    idx,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [REG_W-1:0]    wmask,
    output logic [REG_W-1:0]    wval
);
    logic [IDX_W-1:0] nib_shift;
    logic [IDX_W-1:0] byt_shift;

    assign nib_shift = IDX_W'(idx[NSEL_W-1:0]) << NIB_SH;
    assign byt_shift = IDX_W'(idx[BSEL_W-1:0]) << BYT_SH;

    always_comb begin
        wmask = '0;
        wval  = '0;
        unique case (width)
            ACC_BIT: begin
                wmask = REG_W'(1) << idx;
                wval  = {REG_W{wdata[0]}};
            end
            ACC_NIB: begin
                wmask = REG_W'({NIB_W{1'b1}}) << nib_shift;
                wval  = {(REG_W / NIB_W){wdata[NIB_W-1:0]}};
            end
            ACC_BYTE: begin
                wmask = REG_W'({BYTE_W{1'b1}}) << byt_shift;
                wval  = {(REG_W / BYTE_W){wdata}};
            end
            default: begin
                wmask = '0;
                wval  = '0;
            end
        endcase
    end
endmodule

// File: rtl/bsc_read_mux.sv
// Selects bit, nibble or byte for the read port and the pointer-selected bit.
module bsc_read_mux
    import bsc_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int NIB_W  = 4,
    parameter int BYTE_W = 8,
    localparam int IDX_W  = $clog2(REG_W),
    localparam int N_NIB  = REG_W / NIB_W,
    localparam int N_BYT  = REG_W / BYTE_W,
    localparam int NSEL_W = $clog2(N_NIB),
    localparam int BSEL_W = N_BYT > 1 ? $clog2(N_BYT) : 1
) (
    input  logic [REG_W-1:0]  data,
    input  acc_width_e        width,
    input  logic [IDX_W-1:0]  idx,
    input  logic [IDX_W-1:0]  ptr,
    output logic [BYTE_W-1:0] rdata,
    output logic              seq_bit
);
    logic [NIB_W-1:0]  nib_lane [N_NIB];
    logic [BYTE_W-1:0] byt_lane [N_BYT];

    for (genvar g = 0; g < N_NIB; g++) begin : g_nib
        assign nib_lane[g] = data[g*NIB_W +: NIB_W];
    end
    for (genvar g = 0; g < N_BYT; g++) begin : g_byt
        assign byt_lane[g] = data[g*BYTE_W +: BYTE_W];
    end

    always_comb begin
        unique case (width)
            ACC_BIT:  rdata = BYTE_W'(data[idx]);
            ACC_NIB:  rdata = BYTE_W'(nib_lane[idx[NSEL_W-1:0]]);
            ACC_BYTE: rdata = byt_lane[idx[BSEL_W-1:0]];
            default:  rdata = '0;
        endcase
    end

    assign seq_bit = data[ptr];
endmodule

// File: rtl/bsc_carrier.sv
module bsc_carrier
    import bsc_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int NIB_W  = 4,
    parameter int BYTE_W = 8,
    localparam int IDX_W = $clog2(REG_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [1:0]        acc_width,
    input  logic [IDX_W-1:0]  acc_idx,
    input  logic              acc_ind,
    input  logic [IDX_W-1:0]  ptr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              seq_bit
);
    acc_width_e       width;
    logic [IDX_W-1:0] eff_idx;
    logic [REG_W-1:0] wmask;
    logic [REG_W-1:0] wval;
    logic [REG_W-1:0] data_q;
    logic             do_write;

    assign width    = acc_width_e'(acc_width);
    assign eff_idx  = (acc_ind && width == ACC_BIT) ? ptr : acc_idx;
    assign do_write = acc_en && acc_wr;

    bsc_write_lanes #(.REG_W(REG_W), .NIB_W(NIB_W), .BYTE_W(BYTE_W)) u_lanes (
        .width (width),
        .idx   (eff_idx),
        .wdata (wdata),
        .wmask (wmask),
        .wval  (wval)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            data_q <= '0;
        else if (do_write)
            data_q <= (data_q & ~wmask) | (wval & wmask);
    end

    bsc_read_mux #(.REG_W(REG_W), .NIB_W(NIB_W), .BYTE_W(BYTE_W)) u_rmux (
        .data    (data_q),
        .width   (width),
        .idx     (eff_idx),
        .ptr     (ptr),
        .rdata   (rdata),
        .seq_bit (seq_bit)
    );

    // R1: reset leaves the register cleared
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (data_q == '0));

    // R9: no strobe, no change
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !do_write |=> $stable(data_q));

    // R8: reserved width never writes
    p_rsvd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (do_write && width == ACC_RSVD) |=> $stable(data_q));

    // R2: a bit write flips at most one bit
    p_bit_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (do_write && width == ACC_BIT) |=>
            ($countones(data_q ^ $past(data_q)) <= 1));

    // R3: a nibble write disturbs nothing outside its lane
    p_nib_confined_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (do_write && width == ACC_NIB) |=>
            (((data_q ^ $past(data_q)) & ~$past(wmask)) == '0));

    // R5, R6: an indirect bit write shows up on the pointer output
    p_ind_to_seq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (do_write && width == ACC_BIT && acc_ind) |=>
            ($stable(ptr) -> (seq_bit == $past(wdata[0]))));
endmodule

// File: tb/bsc_carrier_tb.sv
module bsc_carrier_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       acc_en, acc_wr, acc_ind;
    logic [1:0] acc_width;
    logic [3:0] acc_idx, ptr;
    logic [7:0] wdata, rdata;
    logic       seq_bit;

    int          vecs = 0;
    int          errs = 0;
    bit          finished = 0;
    logic [15:0] model;

    always #10 clk = ~clk;

    bsc_carrier u_dut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_width(acc_width), .acc_idx(acc_idx), .acc_ind(acc_ind),
        .ptr(ptr), .wdata(wdata), .rdata(rdata), .seq_bit(seq_bit)
    );

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(logic [15:0] m, logic [1:0] w, logic [3:0] i);
        case (w)
            2'd0:    return {7'b0, m[i]};
            2'd1:    return {4'b0, m[{i[1:0], 2'b00} +: 4]};
            2'd2:    return m[{i[0], 3'b000} +: 8];
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [3:0] pick(logic [1:0] w, logic [3:0] i, logic ind, logic [3:0] p);
        return (ind && w == 2'd0) ? p : i;
    endfunction

    task automatic wr(logic [1:0] w, logic [3:0] i, logic ind, logic [3:0] p, logic [7:0] d);
        logic [3:0] k;
        @(negedge clk);
        acc_en = 1; acc_wr = 1; acc_width = w; acc_idx = i; acc_ind = ind; ptr = p; wdata = d;
        @(negedge clk);
        acc_en = 0; acc_wr = 0; acc_ind = 0;
        k = pick(w, i, ind, p);
        case (w)
            2'd0: model[k] = d[0];
            2'd1: model[{k[1:0], 2'b00} +: 4] = d[3:0];
            2'd2: model[{k[0], 3'b000} +: 8] = d;
            default: ;
        endcase
    endtask

    task automatic rd(string req, logic [1:0] w, logic [3:0] i, logic ind, logic [3:0] p);
        @(negedge clk);
        acc_width = w; acc_idx = i; acc_ind = ind; ptr = p;
        #2 chk(req, {8'h00, rdata}, {8'h00, exp_read(model, w, pick(w, i, ind, p))});
        acc_ind = 0;
    endtask

    task automatic rd_all(string req);
        for (int n = 0; n < 4; n++) rd(req, 2'd1, 4'(n), 1'b0, 4'd0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        vecs++; errs++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [3:0] p;
        rst_n = 0; acc_en = 0; acc_wr = 0; acc_ind = 0;
        acc_width = 2'd2; acc_idx = 0; ptr = 0; wdata = 0; model = 16'h0000;
        repeat (3) @(negedge clk);
        #2 chk("R1 in reset", {8'h00, rdata}, 16'h0000);
        rst_n = 1;
        rd("R1 byte0", 2'd2, 4'd0, 1'b0, 4'd0);
        rd("R1 byte1", 2'd2, 4'd1, 1'b0, 4'd0);
        for (int k = 0; k < 16; k++) begin
            @(negedge clk); ptr = 4'(k);
            #2 chk("R1 seq_bit", {15'b0, seq_bit}, 16'h0000);
        end

        // R2: direct bit writes, set then clear a pattern
        for (int i = 0; i < 16; i++) begin
            wr(2'd0, 4'(i), 1'b0, ~4'(i), {7'b0, 1'((i * 5 + 1) % 3 != 0)});
            rd_all("R2 bit write");
        end
        for (int i = 15; i >= 0; i -= 3) begin
            wr(2'd0, 4'(i), 1'b0, 4'(i), 8'hFE ^ 8'(i & 1));
            rd_all("R2 bit rewrite");
        end

        // R3: nibble writes
        for (int n = 0; n < 4; n++) begin
            wr(2'd1, 4'(n) | 4'b1100, 1'b0, 4'd0, 8'hA0 | 8'((n * 5 + 3) & 15));
            rd_all("R3 nibble write");
        end

        // R4: byte writes, upper index bits set to prove alignment
        wr(2'd2, 4'b1110, 1'b0, 4'd0, 8'h3C);
        rd_all("R4 byte0 write");
        wr(2'd2, 4'b0111, 1'b0, 4'd0, 8'hE1);
        rd_all("R4 byte1 write");

        // R5: indirect writes, pointer stepping up through wrap, then down
        p = 4'd13;
        for (int s = 0; s < 20; s++) begin
            wr(2'd0, ~p, 1'b1, p, {7'b0, 1'(s[0] ^ s[2])});
            rd_all("R5 indirect write up");
            rd("R5 indirect read", 2'd0, ~p, 1'b1, p);
            p = p + 4'd1;
        end
        for (int s = 0; s < 20; s++) begin
            wr(2'd0, ~p, 1'b1, p, {7'b0, 1'(s[1] | s[0])});
            rd_all("R5 indirect write down");
            p = p - 4'd1;
        end

        // R6: stream a pattern through the pointer output both ways
        wr(2'd2, 4'd0, 1'b0, 4'd0, 8'hC3);
        wr(2'd2, 4'd1, 1'b0, 4'd0, 8'hA5);
        p = 4'd0;
        for (int s = 0; s < 34; s++) begin
            @(negedge clk); ptr = p;
            #2 chk("R6 seq up", {15'b0, seq_bit}, {15'b0, model[p]});
            p = p + 4'd1;
        end
        for (int s = 0; s < 34; s++) begin
            @(negedge clk); ptr = p;
            #2 chk("R6 seq down", {15'b0, seq_bit}, {15'b0, model[p]});
            p = p - 4'd1;
        end

        // R7: every width and index on the read port
        for (int w = 0; w < 3; w++)
            for (int i = 0; i < 16; i++)
                rd("R7 read sweep", 2'(w), 4'(i), 1'b0, ~4'(i));

        // R8: reserved width
        wr(2'd3, 4'd0, 1'b0, 4'd0, 8'hFF);
        rd_all("R8 reserved write");
        rd("R8 reserved read", 2'd3, 4'd0, 1'b0, 4'd0);

        // R9: missing strobe or missing write flag
        @(negedge clk);
        acc_en = 0; acc_wr = 1; acc_width = 2'd2; acc_idx = 0; wdata = ~model[7:0];
        @(negedge clk);
        acc_en = 1; acc_wr = 0; acc_idx = 1; wdata = ~model[15:8];
        @(negedge clk);
        acc_en = 0;
        rd_all("R9 no write");

        finish_run();
    end
endmodule